// File: doc/BRIEF.md
# I2C Controller SCL Generator with Clock Synchronization

This block produces the serial clock drive for an I2C controller. A 16-bit divisor, given as two bytes, sets the bit period in ticks of a selected source clock. The block works as an open-drain driver: it asserts a pull-low enable for the low phase and releases the line for the high phase. It watches the wired-AND bus line through a synchronizer, so other controllers and clock-stretching targets can shape the real clock. The low phase restarts whenever someone else drags the line low. The high phase is timed only once the line has actually been seen high.

Each source clock is delivered as a one-cycle tick enable in the block's own clock domain, so the block never switches between clocks. A transaction engine can hold the line low at the end of a low phase with a stall request, for example while it waits for a buffer. Two strobes tell the data path when to change SDA (the middle of the low phase) and when to sample it (the start of the observed high phase). A status output flags the line as held low. All pins are plain control and status signals, and there is no stream interface.

Top module: `scl_clock_gen`

## Requirements
- R1: The divisor N is `div_lo + 256*div_hi`. For an even N the block pulls SCL low for N/2 source ticks and times N/2 ticks of high after the line is seen high.
- R2: For an odd N the low phase lasts (N+1)/2 ticks and the high phase lasts (N-1)/2 ticks, so the extra tick goes to the low phase.
- R3: N is raised to a floor of 4 when `multi_ctl`=0 and to a floor of 8 when `multi_ctl`=1. Every low phase therefore lasts at least 2 ticks.
- R4: `src_sel` picks the tick source: 2'b00 uses `tick_ext`, 2'b01 uses `tick_aux`, and 2'b10 or 2'b11 use `tick_main`. Phase lengths count only the selected ticks.
- R5: After its low count ends, the block releases SCL. It does not start the high count while the synchronized line is low, however long the line is held.
- R6: If the synchronized line reads low during the high phase, the block pulls low at once and starts a full new low count.
- R7: If `stall_req` is 1 when a low count ends, SCL stays pulled low until `stall_req` is 0. The block releases SCL on the first clock edge at which `stall_req` is 0.
- R8: `scl_low_flag` is 1 while the block is in a stall, and while it has released SCL but the synchronized line is still low. It is 0 during an ordinary low or high phase.
- R9: Each low phase gives exactly one `sda_shift_stb`, on the tick that completes floor(low/2) ticks. Each high phase gives exactly one `sda_sample_stb`, in the cycle the synchronized line is first seen high. The two strobes never coincide.
- R10: With `ctl_en`=0 the block is idle. `scl_pull`, both strobes and `scl_low_flag` are 0, and the tick inputs and `src_sel` have no effect. Setting `ctl_en` starts a low phase on the next edge.
- R11: During and right after reset, `scl_pull`, both strobes and `scl_low_flag` are 0.
- R12: `scl_in` passes through SYNC_STAGES flip-flops, 2 by default. With `tick_main` on every cycle, the released time is high + SYNC_STAGES + 1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_en | input | 1 | Controller mode enable; 0 leaves the generator idle |
| multi_ctl | input | 1 | Multi-controller bus; raises the divisor floor to 8 |
| src_sel | input | 2 | Tick source select |
| tick_ext | input | 1 | External source tick enable |
| tick_aux | input | 1 | Auxiliary source tick enable |
| tick_main | input | 1 | Main source tick enable |
| div_lo | input | 8 | Divisor low byte |
| div_hi | input | 8 | Divisor high byte |
| stall_req | input | 1 | Hold SCL low at the end of the low phase |
| scl_in | input | 1 | Sampled SCL bus line |
| scl_pull | output | 1 | Pull-low enable for the SCL driver |
| sda_shift_stb | output | 1 | Mid-low strobe for changing SDA |
| sda_sample_stb | output | 1 | Start-of-high strobe for sampling SDA |
| scl_low_flag | output | 1 | SCL held low by a stall or by another device |

## Verification
The bench measures low and high durations for an even divisor that has a nonzero high byte, for an odd divisor, and for divisors below both floors. A wrong split or a missed clamp shows up as an off-by-one or a phase that is too short. It stretches the line after release and checks that the high count waits. A design that counts from its own release would pull low again too early. It also pulls the line low in the middle of the high phase and expects a full new low count, which a design that ignores synchronization would not give. Further tests hold a stall over many cycles, check the strobe counts per period, and confirm that ticks and the source select do nothing in idle mode.

// File: rtl/sclg_pkg.sv
package sclg_pkg;
  localparam int DIV_W = 16;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOW,
    PH_STALL,
    PH_WAIT_HI,
    PH_HIGH
  } phase_t;

  typedef logic [DIV_W-1:0] div_t;
endpackage

// File: rtl/sclg_tick_sel.sv
module sclg_tick_sel (
  input  logic       en,
  input  logic [1:0] sel,
  input  logic       tick_ext,
  input  logic       tick_aux,
  input  logic       tick_main,
  output logic       tick
);
  always_comb begin
    tick = 1'b0;
    if (en) begin
      unique case (sel)
        2'b00:   tick = tick_ext;
        2'b01:   tick = tick_aux;
        default: tick = tick_main;
      endcase
    end
  end
endmodule

// File: rtl/sclg_div_split.sv
module sclg_div_split
  import sclg_pkg::*;
#(
  parameter int MIN_SINGLE = 4,
  parameter int MIN_MULTI  = 8
) (
  input  logic [7:0] div_lo,
  input  logic [7:0] div_hi,
  input  logic       multi,
  output div_t       low_len,
  output div_t       high_len,
  output div_t       low_half
);
  localparam div_t FLOOR_S = div_t'(MIN_SINGLE);
  localparam div_t FLOOR_M = div_t'(MIN_MULTI);

  div_t raw, floor_v, eff;

  always_comb begin
    raw      = {div_hi, div_lo};
    floor_v  = multi ? FLOOR_M : FLOOR_S;
    eff      = (raw < floor_v) ? floor_v : raw;
    high_len = eff >> 1;
    low_len  = eff - high_len;
    low_half = low_len >> 1;
  end
endmodule

// File: rtl/sclg_line_sync.sv
module sclg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[0] <= 1'b0;
          else        pipe[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[i] <= 1'b0;
          else        pipe[i] <= pipe[i-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sclg_phase_fsm.sv
module sclg_phase_fsm
  import sclg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic line_hi,
  input  logic stall_req,
  input  div_t low_len,
  input  div_t high_len,
  input  div_t low_half,
  output logic pull,
  output logic shift_stb,
  output logic sample_stb,
  output logic low_flag
);
  phase_t state, state_nx;
  div_t   cnt, cnt_nx;
  logic [DIV_W:0] cnt_inc;
  logic low_done, high_done;

  assign cnt_inc   = {1'b0, cnt} + 1'b1;
  assign low_done  = tick && (cnt_inc >= {1'b0, low_len});
  assign high_done = tick && (cnt_inc >= {1'b0, high_len});

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    unique case (state)
      PH_IDLE: begin
        state_nx = PH_LOW;
        cnt_nx   = '0;
      end
      PH_LOW: begin
        if (low_done) begin
          state_nx = stall_req ? PH_STALL : PH_WAIT_HI;
          cnt_nx   = '0;
        end else if (tick) begin
          cnt_nx = cnt_inc[DIV_W-1:0];
        end
      end
      PH_STALL: begin
        if (!stall_req) state_nx = PH_WAIT_HI;
      end
      PH_WAIT_HI: begin
        if (line_hi) begin
          state_nx = PH_HIGH;
          cnt_nx   = '0;
        end
      end
      PH_HIGH: begin
        if (!line_hi || high_done) begin
          state_nx = PH_LOW;
          cnt_nx   = '0;
        end else if (tick) begin
          cnt_nx = cnt_inc[DIV_W-1:0];
        end
      end
      default: begin
        state_nx = PH_IDLE;
        cnt_nx   = '0;
      end
    endcase
    if (!en) begin
      state_nx = PH_IDLE;
      cnt_nx   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PH_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      cnt   <= cnt_nx;
    end
  end

  assign pull       = (state == PH_LOW) || (state == PH_STALL);
  assign shift_stb  = en && (state == PH_LOW) && tick &&
                      (cnt_inc == {1'b0, low_half});
  assign sample_stb = en && (state == PH_WAIT_HI) && line_hi;
  assign low_flag   = en && ((state == PH_STALL) ||
                             ((state == PH_WAIT_HI) && !line_hi));
endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import sclg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_SINGLE  = 4,
  parameter int MIN_MULTI   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_en,
  input  logic       multi_ctl,
  input  logic [1:0] src_sel,
  input  logic       tick_ext,
  input  logic       tick_aux,
  input  logic       tick_main,
  input  logic [7:0] div_lo,
  input  logic [7:0] div_hi,
  input  logic       stall_req,
  input  logic       scl_in,
  output logic       scl_pull,
  output logic       sda_shift_stb,
  output logic       sda_sample_stb,
  output logic       scl_low_flag
);
  logic tick, line_hi;
  div_t low_len, high_len, low_half;

  sclg_tick_sel u_tick (
    .en(ctl_en), .sel(src_sel), .tick_ext(tick_ext),
    .tick_aux(tick_aux), .tick_main(tick_main), .tick(tick)
  );

  sclg_div_split #(.MIN_SINGLE(MIN_SINGLE), .MIN_MULTI(MIN_MULTI)) u_div (
    .div_lo(div_lo), .div_hi(div_hi), .multi(multi_ctl),
    .low_len(low_len), .high_len(high_len), .low_half(low_half)
  );

  sclg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(line_hi)
  );

  sclg_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .tick(tick),
    .line_hi(line_hi), .stall_req(stall_req),
    .low_len(low_len), .high_len(high_len), .low_half(low_half),
    .pull(scl_pull), .shift_stb(sda_shift_stb),
    .sample_stb(sda_sample_stb), .low_flag(scl_low_flag)
  );
endmodule

// File: rtl/sclg_checker.sv
module sclg_checker (
  input logic clk,
  input logic rst_n,
  input logic ctl_en,
  input logic stall_req,
  input logic scl_pull,
  input logic sda_shift_stb,
  input logic sda_sample_stb,
  input logic scl_low_flag
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> (!scl_pull && !sda_shift_stb && !sda_sample_stb && !scl_low_flag)); // R10

  AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_pull) && $past(ctl_en)) |-> !$past(stall_req)); // R7

  AST_FLAG_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_low_flag && scl_pull) |-> $past(stall_req)); // R8

  AST_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull) |=> (scl_pull || !$past(ctl_en))); // R3

  AST_SHIFT_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sda_shift_stb |-> (scl_pull && !scl_low_flag)); // R9

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sda_shift_stb && sda_sample_stb)); // R9
endmodule

bind scl_clock_gen sclg_checker u_sclg_checker (
  .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .stall_req(stall_req),
  .scl_pull(scl_pull), .sda_shift_stb(sda_shift_stb),
  .sda_sample_stb(sda_sample_stb), .scl_low_flag(scl_low_flag)
);

// File: tb/test_scl_clock_gen.sv
`timescale 1ns/1ps
module test_scl_clock_gen;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_en = 1'b0, multi_ctl = 1'b0, stall_req = 1'b0, ext_hold = 1'b0;
  logic [1:0] src_sel = 2'b11;
  logic [7:0] div_lo = 8'd10, div_hi = 8'd0;
  logic scl_pull, sda_shift_stb, sda_sample_stb, scl_low_flag;
  int unsigned ph = 0;
  logic tick_ext, tick_aux, tick_main;
  wire scl_line = ~(scl_pull | ext_hold);

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  initial forever begin
    @(negedge clk);
    ph++;
  end
  assign tick_ext  = (ph % 2) == 0;
  assign tick_aux  = (ph % 3) == 0;
  assign tick_main = 1'b1;

  scl_clock_gen #(.SYNC_STAGES(SYNC)) i_scl_clock_gen (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .multi_ctl(multi_ctl),
    .src_sel(src_sel), .tick_ext(tick_ext), .tick_aux(tick_aux),
    .tick_main(tick_main), .div_lo(div_lo), .div_hi(div_hi),
    .stall_req(stall_req), .scl_in(scl_line), .scl_pull(scl_pull),
    .sda_shift_stb(sda_shift_stb), .sda_sample_stb(sda_sample_stb),
    .scl_low_flag(scl_low_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int lo, output int hi);
    int g = 0;
    while (scl_pull !== 1'b0 && g < 20000) begin g++; @(negedge clk); end
    while (scl_pull !== 1'b1 && g < 20000) begin g++; @(negedge clk); end
    lo = 0;
    while (scl_pull === 1'b1 && lo < 20000) begin lo++; @(negedge clk); end
    hi = 0;
    while (scl_pull === 1'b0 && hi < 20000) begin hi++; @(negedge clk); end
  endtask

  task automatic setup(input int n, input bit multi, input logic [1:0] sel);
    div_lo = n[7:0]; div_hi = n[15:8]; multi_ctl = multi; src_sel = sel;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(scl_pull == 0 && sda_shift_stb == 0 && sda_sample_stb == 0 && scl_low_flag == 0,
        "R11 reset outputs", {scl_pull, sda_shift_stb, sda_sample_stb, scl_low_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl_pull == 0 && scl_low_flag == 0, "R11 after reset idle", scl_pull, 0);
  endtask

  task automatic t_even();
    int lo, hi;
    setup(262, 0, 2'b11);
    measure(lo, hi); measure(lo, hi);
    chk(lo == 131, "R1 even low (0x0106)", lo, 131);
    chk(hi == 131 + LAT, "R1 R12 even high", hi, 131 + LAT);
    setup(10, 0, 2'b11);
    measure(lo, hi); measure(lo, hi);
    chk(lo == 5, "R1 even low 10", lo, 5);
    chk(hi == 5 + LAT, "R5 R12 high after line seen", hi, 5 + LAT);
  endtask

  task automatic t_odd();
    int lo, hi;
    setup(9, 0, 2'b11);
    measure(lo, hi); measure(lo, hi);
    chk(lo == 5, "R2 odd low", lo, 5);
    chk(hi == 4 + LAT, "R2 odd high", hi, 4 + LAT);
  endtask

  task automatic t_clamp();
    int lo, hi;
    setup(1, 0, 2'b11);
    measure(lo, hi); measure(lo, hi);
    chk(lo == 2, "R3 single floor low", lo, 2);
    chk(hi == 2 + LAT, "R3 single floor high", hi, 2 + LAT);
    setup(5, 1, 2'b11);
    measure(lo, hi); measure(lo, hi);
    chk(lo == 4, "R3 multi floor low", lo, 4);
    chk(hi == 4 + LAT, "R3 multi floor high", hi, 4 + LAT);
    setup(10, 1, 2'b11);
    measure(lo, hi); measure(lo, hi);
    chk(lo == 5, "R3 multi above floor", lo, 5);
  endtask

  task automatic t_src();
    int lo, hi;
    setup(6, 0, 2'b00);
    measure(lo, hi); measure(lo, hi);
    chk(lo >= 5 && lo <= 6, "R4 ext source low", lo, 6);
    setup(6, 0, 2'b01);
    measure(lo, hi); measure(lo, hi);
    chk(lo >= 7 && lo <= 9, "R4 aux source low", lo, 9);
    setup(6, 0, 2'b10);
    measure(lo, hi); measure(lo, hi);
    chk(lo == 3, "R4 main source via 10", lo, 3);
  endtask

  task automatic t_strobes();
    int lo, hi, nsh, nsa, badsa, g;
    setup(10, 0, 2'b11);
    measure(lo, hi);
    nsh = 0; nsa = 0; badsa = 0; g = 0;
    while (scl_pull === 1'b1 && g < 1000) begin
      if (sda_shift_stb) nsh++;
      if (sda_sample_stb) nsa++;
      g++; @(negedge clk);
    end
    while (scl_pull === 1'b0 && g < 1000) begin
      if (sda_shift_stb) nsh++;
      if (sda_sample_stb) begin nsa++; if (scl_line !== 1'b1) badsa++; end
      g++; @(negedge clk);
    end
    chk(nsh == 1, "R9 one shift strobe per period", nsh, 1);
    chk(nsa == 1, "R9 one sample strobe per period", nsa, 1);
    chk(badsa == 0, "R9 sample while line high", badsa, 0);
  endtask

  task automatic t_stretch();
    int lo, hi, n, nsa;
    setup(8, 0, 2'b11);
    measure(lo, hi);
    while (scl_pull !== 1'b1) @(negedge clk);
    while (scl_pull !== 1'b0) @(negedge clk);
    ext_hold = 1'b1;
    nsa = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sda_sample_stb || scl_pull) nsa++;
    end
    chk(nsa == 0, "R5 no high count while stretched", nsa, 0);
    chk(scl_low_flag == 1, "R8 flag on external hold", scl_low_flag, 1);
    ext_hold = 1'b0;
    n = 0;
    while (scl_pull === 1'b0 && n < 1000) begin n++; @(negedge clk); end
    chk(n == 4 + LAT, "R5 R12 high after stretch", n, 4 + LAT);
  endtask

  task automatic t_restart();
    int lo, hi, n;
    setup(20, 0, 2'b11);
    measure(lo, hi);
    while (scl_pull !== 1'b1) @(negedge clk);
    while (scl_pull !== 1'b0) @(negedge clk);
    n = 0;
    repeat (5) begin n++; @(negedge clk); end
    ext_hold = 1'b1;
    repeat (2) begin n++; @(negedge clk); end
    ext_hold = 1'b0;
    while (scl_pull === 1'b0 && n < 1000) begin n++; @(negedge clk); end
    chk(n < 10 + LAT, "R6 early pull on sync", n, 10 + LAT);
    lo = 0;
    while (scl_pull === 1'b1 && lo < 1000) begin lo++; @(negedge clk); end
    chk(lo == 10, "R6 full low after restart", lo, 10);
  endtask

  task automatic t_stall();
    int lo, hi;
    setup(8, 0, 2'b11);
    measure(lo, hi);
    while (scl_pull !== 1'b1) @(negedge clk);
    chk(scl_low_flag == 0, "R8 flag clear in own low", scl_low_flag, 0);
    stall_req = 1'b1;
    repeat (30) @(negedge clk);
    chk(scl_pull == 1, "R7 held during stall", scl_pull, 1);
    chk(scl_low_flag == 1, "R8 flag during stall", scl_low_flag, 1);
    stall_req = 1'b0;
    @(negedge clk);
    chk(scl_pull == 0, "R7 release after stall", scl_pull, 0);
  endtask

  task automatic t_target();
    int errs = 0;
    ctl_en = 1'b0;
    ext_hold = 1'b1;
    for (int i = 0; i < 40; i++) begin
      src_sel = 2'(i);
      @(negedge clk);
      if (scl_pull || sda_shift_stb || sda_sample_stb || scl_low_flag) errs++;
    end
    ext_hold = 1'b0;
    src_sel = 2'b11;
    chk(errs == 0, "R10 idle in target mode", errs, 0);
    ctl_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(scl_pull == 1, "R10 start after enable", scl_pull, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    ctl_en = 1'b1;
    t_even();
    t_odd();
    t_clamp();
    t_src();
    t_strobes();
    t_stretch();
    t_restart();
    t_stall();
    t_target();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule